// File: doc/BRIEF.md
# Burst-Counting Synchronous SRAM

This block is a single-port synchronous memory whose read path is flow-through. Address, control and write data are captured on the rising clock edge, and the addressed word drives the data output in the cycle that follows that edge, with no output register. One start address produces a burst of four beats. The upper address bits stay fixed for the whole burst. The two low bits come from a two-bit beat counter, combined with the low bits of the start address in either linear (wrapping increment) or interleaved (XOR) order. The `lin_order` input selects the order.

A burst starts on either of two address-load strobes. `ld_ctl_n` is always honoured. `ld_cpu_n` only counts when `ce_n` is low. A start cycle selects the chip only when all three chip selects are active, and a start cycle with the chip not selected ends the burst. Between starts, `adv_n` steps the beat counter. Writes use a global write, or byte-enable gated per-lane writes, on four 9-bit lanes. A sleep input freezes all state and blocks writes. The output enable acts asynchronously on the data output.

Top module: `burst_sram`

## Requirements
- R1: After an edge that starts a selected read at address A, `rd_valid` is 1 and `rdata` equals the word at A in the cycle that follows that edge. After any edge that writes, `rd_valid` is 0 for that cycle.
- R2: With `lin_order`=1, beat k (k=0..3) of a burst starting at A reads address {A[hi:2], (A[1:0]+k) mod 4}.
- R3: With `lin_order`=0, beat k of a burst starting at A reads address {A[hi:2], A[1:0] XOR k}.
- R4: The beat counter advances only on edges with `adv_n`=0 and no load strobe. Otherwise it holds. After the fourth beat it wraps to beat 0.
- R5: `ld_cpu_n`=0 has no effect when `ce_n`=1. `ld_ctl_n`=0 starts a burst regardless of `ce_n`.
- R6: A load strobe on an edge restarts the burst at the new address, and `adv_n` on that edge is ignored.
- R7: `gw_n`=0 writes all four lanes, whatever the values of `bwe_n` and `bw_n`.
- R8: With `gw_n`=1 and `bwe_n`=0, lane i (bits 9i+8..9i) is written exactly when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R9: While `sleep`=1, no write takes effect, the burst state holds, and after that edge `rd_valid` is 0.
- R10: The chip is selected on a start edge only if `ce_n`=0, `cs_hi`=1 and `cs_n`=0. A start with the chip not selected drops `rd_valid` on that same edge and blocks writes until the next selected start.
- R11: `oe_n`=1 forces `rd_valid` to 0 and `rdata` to 0 with no clock edge.
- R12: While reset is held, `rd_valid` is 0 and `rdata` is 0.
- R13: A write sampled on an edge lands at the beat address in effect after that edge, so a four-edge burst of writes fills the burst sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Start address, sampled on load edges |
| ce_n | input | 1 | Chip enable, active low; also gates `ld_cpu_n` |
| cs_hi | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| ld_cpu_n | input | 1 | Address-load strobe gated by `ce_n`, active low |
| ld_ctl_n | input | 1 | Address-load strobe, always honoured, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Power-down, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, 0 when not valid |
| rd_valid | output | 1 | Output-valid flag |

## Verification
The bench builds the block with ADDR_W=4, LANES=4 and LANE_W=9. This gives a 16-word array that holds four aligned burst groups. The small array lets the bench run both burst orders from every start address through all four beats and the wrap. It also applies all sixteen byte-select masks to one word and checks each one against a shadow copy. Load-strobe gating, chip-select gating, sleep and output enable are each exercised in targeted sequences on the same words.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   localparam int BEAT_W = 2;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_STEP = 2'd2
   } op_e;

   function automatic logic [BEAT_W-1:0] beat_offset(
      input logic [BEAT_W-1:0] start,
      input logic [BEAT_W-1:0] beat,
      input logic              linear
   );
      return linear ? (start + beat) : (start ^ beat);
   endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
   import burst_sram_pkg::*;
(
   input  logic ce_n,
   input  logic cs_hi,
   input  logic cs_n,
   input  logic ld_cpu_n,
   input  logic ld_ctl_n,
   input  logic adv_n,
   input  logic sleep,
   input  logic act_q,
   output op_e  op,
   output logic sel
);
   logic start;

   always_comb begin
      start = !ld_ctl_n || (!ld_cpu_n && !ce_n);
      sel   = !ce_n && cs_hi && !cs_n;
      if (sleep)                op = OP_HOLD;
      else if (start)           op = OP_LOAD;
      else if (!adv_n && act_q) op = OP_STEP;
      else                      op = OP_HOLD;
   end

endmodule

// File: rtl/bsr_burst.sv
module bsr_burst
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              sel,
   input  logic              linear,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              act_q,
   output logic              nxt_act
);
   localparam int HI_W = ADDR_W - BEAT_W;

   logic [ADDR_W-1:0] base_q, nxt_base;
   logic [BEAT_W-1:0] cnt_q, nxt_cnt;

   if (ADDR_W < BEAT_W + 1) begin : g_bad_addr
      $error("bsr_burst: ADDR_W must exceed the beat counter width");
   end

   always_comb begin
      nxt_base = base_q;
      nxt_cnt  = cnt_q;
      nxt_act  = act_q;
      unique case (op)
         OP_LOAD: begin
            nxt_base = load_addr;
            nxt_cnt  = '0;
            nxt_act  = sel;
         end
         OP_STEP: nxt_cnt = cnt_q + 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         base_q <= nxt_base;
         cnt_q  <= nxt_cnt;
         act_q  <= nxt_act;
      end
   end

   assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                      beat_offset(base_q[BEAT_W-1:0], cnt_q, linear)};
   assign nxt_addr = {nxt_base[ADDR_W-1 -: HI_W],
                      beat_offset(nxt_base[BEAT_W-1:0], nxt_cnt, linear)};

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_HOLD |=> $stable(cnt_q) && $stable(base_q));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STEP && cnt_q == 2'd3) |=> cnt_q == 2'd0);
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LOAD |=> cnt_q == 2'd0 && base_q == $past(load_addr));

endmodule

// File: rtl/bsr_wmask.sv
module bsr_wmask #(
   parameter int LANES = 4
)(
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = !gw_n || (!bwe_n && !bw_n[g]);
   end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];

      p_lane_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
         we[g] |=> mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W]));
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    ce_n,
   input  logic                    cs_hi,
   input  logic                    cs_n,
   input  logic                    ld_cpu_n,
   input  logic                    ld_ctl_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    lin_order,
   input  logic                    sleep,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rd_valid
);
   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_W must be positive");
   end

   op_e               op;
   logic              sel, act_q, nxt_act, wr_q, sleep_q;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic [LANES-1:0]  lane_we, we_eff;
   logic [DATA_W-1:0] arr_rd;

   bsr_ctrl u_ctrl (
      .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n),
      .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .adv_n(adv_n),
      .sleep(sleep), .act_q(act_q), .op(op), .sel(sel)
   );

   bsr_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .op(op), .load_addr(addr), .sel(sel),
      .linear(lin_order), .cur_addr(cur_addr), .nxt_addr(nxt_addr),
      .act_q(act_q), .nxt_act(nxt_act)
   );

   bsr_wmask #(.LANES(LANES)) u_wmask (
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lane_we(lane_we)
   );

   assign we_eff = (!sleep && nxt_act) ? lane_we : '0;

   bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .we(we_eff), .waddr(nxt_addr),
      .wdata(wdata), .raddr(cur_addr), .rdata(arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         sleep_q <= 1'b0;
      end else begin
         sleep_q <= sleep;
         if (!sleep) wr_q <= |we_eff;
      end
   end

   assign rd_valid = act_q && !wr_q && !sleep_q && !oe_n;
   assign rdata    = rd_valid ? arr_rd : '0;

   p_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD && !sel) |=> !rd_valid);
   p_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rd_valid);
   p_ctl_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_ctl_n && ce_n && !sleep) |=> !rd_valid);
   p_cpu_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_cpu_n && ce_n && ld_ctl_n && adv_n && !sleep) |=> $stable(cur_addr));

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
   localparam int AW = 4;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic          ce_n, cs_hi, cs_n, ld_cpu_n, ld_ctl_n, adv_n;
   logic          gw_n, bwe_n, lin_order, sleep, oe_n;
   logic [NL-1:0] bw_n;
   logic [DW-1:0] wdata, rdata;
   logic          rd_valid;

   logic [DW-1:0] sh [1 << AW];
   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_hi(cs_hi),
      .cs_n(cs_n), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lin_order(lin_order),
      .sleep(sleep), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
      .rd_valid(rd_valid)
   );

   task automatic chk(input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
      ce_n = 1'b0; cs_hi = 1'b1; cs_n = 1'b0;
      sleep = 1'b0; oe_n = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic start_rd(input logic [AW-1:0] a, input bit use_cpu);
      idle();
      addr = a;
      if (use_cpu) ld_cpu_n = 1'b0; else ld_ctl_n = 1'b0;
      tick();
      idle();
   endtask

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a,
                                                input int k, input bit lin);
      logic [1:0] kk = 2'(k);
      return {a[AW-1:2], lin ? 2'(a[1:0] + kk) : (a[1:0] ^ kk)};
   endfunction

   function automatic logic [DW-1:0] pat(input int a);
      return (36'(a) * 36'h3_1415_9265) ^ 36'h5_A5A5_A5A5;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle();
      addr = '0; wdata = '0; lin_order = 1'b1;
      repeat (3) tick();
      chk("R12 valid", {35'b0, rd_valid}, 36'd0);
      chk("R12 data", rdata, 36'd0);
      rst_n = 1'b1;
      tick();

      // R7: fill with global writes while byte controls vary
      for (int a = 0; a < 16; a++) begin
         idle();
         ld_ctl_n = 1'b0; gw_n = 1'b0; bwe_n = a[0]; bw_n = 4'(a);
         addr = 4'(a); wdata = pat(a);
         tick();
         chk("R1 write cycle invalid", {35'b0, rd_valid}, 36'd0);
         sh[a] = pat(a);
      end
      for (int a = 0; a < 16; a++) begin
         start_rd(4'(a), 1'b0);
         chk("R7 all lanes", rdata, sh[a]);
      end

      // R2 / R3 sweep: all start addresses, both orders, through the wrap
      for (int lin = 0; lin < 2; lin++) begin
         for (int a = 0; a < 16; a++) begin
            lin_order = lin[0];
            start_rd(4'(a), a[0]);
            chk("R1 valid", {35'b0, rd_valid}, 36'd1);
            chk("R1 data", rdata, sh[a]);
            for (int k = 1; k <= 4; k++) begin
               adv_n = 1'b0;
               tick();
               adv_n = 1'b1;
               chk(lin ? "R2 linear beat" : "R3 interleaved beat",
                   rdata, sh[beat_addr(4'(a), k, lin[0])]);
            end
         end
      end

      // R4: hold without advance
      lin_order = 1'b1;
      start_rd(4'd7, 1'b0);
      tick();
      chk("R4 hold", rdata, sh[7]);
      tick();
      chk("R4 hold", rdata, sh[7]);

      // R6: load overrides advance
      start_rd(4'd4, 1'b0);
      adv_n = 1'b0; tick();
      chk("R6 pre", rdata, sh[5]);
      ld_ctl_n = 1'b0; adv_n = 1'b0; addr = 4'd10; tick(); idle();
      chk("R6 restart", rdata, sh[10]);
      adv_n = 1'b0; tick(); idle();
      chk("R6 next beat", rdata, sh[11]);

      // R5: cpu strobe ignored with ce_n high, ctl strobe honoured
      start_rd(4'd2, 1'b0);
      ld_cpu_n = 1'b0; ce_n = 1'b1; addr = 4'd12; tick(); idle();
      chk("R5 cpu ignored", rdata, sh[2]);
      chk("R5 cpu ignored valid", {35'b0, rd_valid}, 36'd1);
      ld_ctl_n = 1'b0; ce_n = 1'b1; addr = 4'd12; tick(); idle();
      chk("R5 ctl honoured deselect", {35'b0, rd_valid}, 36'd0);
      adv_n = 1'b0; tick(); idle();
      chk("R10 stays deselected", {35'b0, rd_valid}, 36'd0);

      // R10: chip selects
      ld_ctl_n = 1'b0; cs_hi = 1'b0; addr = 4'd3; tick(); idle();
      chk("R10 cs_hi low", {35'b0, rd_valid}, 36'd0);
      ld_ctl_n = 1'b0; cs_n = 1'b1; addr = 4'd3; tick(); idle();
      chk("R10 cs_n high", {35'b0, rd_valid}, 36'd0);
      ld_ctl_n = 1'b0; cs_hi = 1'b0; gw_n = 1'b0; addr = 4'd3;
      wdata = ~sh[3]; tick(); idle();
      start_rd(4'd3, 1'b1);
      chk("R10 no write when deselected", rdata, sh[3]);

      // R8: every byte mask on one word, then bwe_n high
      for (int m = 0; m < 16; m++) begin
         logic [DW-1:0] nw;
         nw = pat(m + 40);
         idle();
         ld_ctl_n = 1'b0; bwe_n = 1'b0; bw_n = 4'(m); addr = 4'd5; wdata = nw;
         tick();
         for (int i = 0; i < NL; i++)
            if (!m[i]) sh[5][i*LW +: LW] = nw[i*LW +: LW];
         start_rd(4'd5, 1'b0);
         chk("R8 byte mask", rdata, sh[5]);
      end
      idle();
      ld_ctl_n = 1'b0; bwe_n = 1'b1; bw_n = 4'b0000; addr = 4'd5; wdata = ~sh[5];
      tick();
      start_rd(4'd5, 1'b0);
      chk("R8 bwe_n high no write", rdata, sh[5]);

      // R13: burst of writes, interleaved order, start offset 1
      lin_order = 1'b0;
      for (int k = 0; k < 4; k++) begin
         idle();
         gw_n = 1'b0;
         if (k == 0) begin ld_ctl_n = 1'b0; addr = 4'd9; end
         else adv_n = 1'b0;
         wdata = pat(k + 90);
         tick();
         sh[beat_addr(4'd9, k, 1'b0)] = pat(k + 90);
      end
      for (int k = 0; k < 4; k++) begin
         start_rd(beat_addr(4'd9, k, 1'b0), 1'b0);
         chk("R13 burst write", rdata, pat(k + 90));
      end

      // R9: sleep blocks writes and freezes the counter
      idle();
      sleep = 1'b1; ld_ctl_n = 1'b0; gw_n = 1'b0; addr = 4'd0; wdata = ~sh[0];
      tick();
      chk("R9 sleep invalid", {35'b0, rd_valid}, 36'd0);
      start_rd(4'd0, 1'b0);
      chk("R9 no write", rdata, sh[0]);
      start_rd(4'd6, 1'b0);
      sleep = 1'b1; adv_n = 1'b0; tick(); idle();
      chk("R9 sleep invalid", {35'b0, rd_valid}, 36'd0);
      tick();
      chk("R9 counter held", rdata, sh[6]);
      chk("R9 valid after wake", {35'b0, rd_valid}, 36'd1);

      // R11: asynchronous output enable
      start_rd(4'd8, 1'b0);
      oe_n = 1'b1; #0.5;
      chk("R11 valid off", {35'b0, rd_valid}, 36'd0);
      chk("R11 data off", rdata, 36'd0);
      oe_n = 1'b0; #0.5;
      chk("R11 data back", rdata, sh[8]);

      finish_run();
   end
endmodule